// File: doc/BRIEF.md
# Pin Change Detector and Interrupt Combiner

This block gathers the interrupt causes of a two-channel serial controller into one active-low request line. Seven causes arrive as one-cycle event pulses from the channels and the timer. Each pulse sets a sticky status bit. The eighth cause is generated inside the block: it watches four general-purpose input pins and flags any change of level on them. An eight-bit mask register selects which status bits may pull the request line low.

Each status bit clears only on its own host action. Reading received data clears a receive bit, and writing transmit data clears a transmit bit. A break-reset command clears a break bit, and a stop-counter command clears the counter bit. Reading the change register clears the pin-change bit.

The change register shows the synchronized pin levels in its low half and one sticky change flag per pin in its high half. A read of the register clears all four flags. A pin change that lands in the same cycle as that read is kept for the next read.

Top module: `change_irq_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, status reads 0x00, the change flags read 0 and irqN is high.
- R2: The status bits are laid out as follows, and each bit is set one cycle after its event pulse and then holds: bit0 channel-A transmit ready (evtSet[0]), bit1 channel-A receive ready (evtSet[1]), bit2 channel-A break change (evtSet[2]), bit3 counter (evtSet[3]), bit4 channel-B transmit ready (evtSet[4]), bit5 channel-B receive ready (evtSet[5]), bit6 channel-B break change (evtSet[6]), bit7 pin change.
- R3: irqN is low exactly when some status bit has its mask bit set. A write of maskData takes effect in the following cycle, so masking a pending bit releases irqN in that cycle.
- R4: rxDataRd[0] clears bit1 and rxDataRd[1] clears bit5. txDataWr[0] clears bit0 and txDataWr[1] clears bit4. A clear strobe leaves every other bit unchanged.
- R5: breakRstCmd[0] clears bit2 and breakRstCmd[1] clears bit6. ctrStopCmd clears bit3.
- R6: When an event pulse and the clear for the same bit arrive in the same cycle, the bit ends up set.
- R7: chgReg[3:0] shows the pin levels through a two-stage synchronizer. A pin level driven between clock edges appears after the second following edge.
- R8: chgReg[4+i] is set one cycle after the synchronized level of pin i differs from its previous sample, for rises and falls alike, and it stays set. Status bit7 is the OR of chgReg[7:4].
- R9: A cycle with chgRd high clears all four change flags, and with them status bit7.
- R10: A change detected in the same cycle as chgRd leaves its flag set after the read.
- R11: Pin levels already present when reset is released raise no change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| evtSet | input | 7 | Event pulses for status bits 0 to 6 |
| rxDataRd | input | 2 | Received-data read strobe per channel (A=0, B=1) |
| txDataWr | input | 2 | Transmit-data write strobe per channel |
| breakRstCmd | input | 2 | Break-change reset command per channel |
| ctrStopCmd | input | 1 | Stop-counter command |
| chgRd | input | 1 | Change register read strobe |
| maskWr | input | 1 | Mask register write strobe |
| maskData | input | 8 | Value loaded into the mask register |
| pinsIn | input | PIN_CNT (4) | Asynchronous monitored input pins |
| irqN | output | 1 | Active-low combined interrupt request |
| status | output | 8 | Latched interrupt status |
| chgReg | output | 2*PIN_CNT (8) | {change flags, synchronized levels} |

## Verification
Two collisions matter. An event pulse can meet the clear strobe of its own status bit, and a synchronized pin change can be detected in the very cycle the host reads the change register. The bench provokes the first by pulsing the channel-A transmit event together with the channel-A transmit-data write. For the second, it times chgRd to the cycle in which a pin edge reaches the comparison stage. In both cases the scoreboard expects the new event to survive, with its status bit still set and irqN still low. A follow-up read then shows that it clears normally.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_CNT = 8;
  localparam int EXT_CNT = SRC_CNT - 1;

  localparam int BIT_TX_A  = 0;
  localparam int BIT_RX_A  = 1;
  localparam int BIT_BRK_A = 2;
  localparam int BIT_CTR   = 3;
  localparam int BIT_TX_B  = 4;
  localparam int BIT_RX_B  = 5;
  localparam int BIT_BRK_B = 6;
  localparam int BIT_CHG   = 7;

  typedef struct packed {
    logic [EXT_CNT-1:0] clrEvt;
    logic               clrDelta;
  } strobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         rxDataRd,
  input  logic [1:0]         txDataWr,
  input  logic [1:0]         breakRstCmd,
  input  logic               ctrStopCmd,
  input  logic               chgRd,
  input  logic               maskWr,
  input  logic [SRC_CNT-1:0] maskData,
  input  logic [SRC_CNT-1:0] status,
  output strobe_t            strb,
  output logic               irqN
);
  logic [SRC_CNT-1:0] maskReg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) maskReg <= '0;
    else if (maskWr) maskReg <= maskData;
  end

  always_comb begin
    strb = '0;
    strb.clrEvt[BIT_TX_A]  = txDataWr[0];
    strb.clrEvt[BIT_RX_A]  = rxDataRd[0];
    strb.clrEvt[BIT_BRK_A] = breakRstCmd[0];
    strb.clrEvt[BIT_CTR]   = ctrStopCmd;
    strb.clrEvt[BIT_TX_B]  = txDataWr[1];
    strb.clrEvt[BIT_RX_B]  = rxDataRd[1];
    strb.clrEvt[BIT_BRK_B] = breakRstCmd[1];
    strb.clrDelta          = chgRd;
  end

  assign irqN = ~|(status & maskReg);
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int PIN_CNT    = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EXT_CNT-1:0]   evtSet,
  input  strobe_t              strb,
  input  logic [PIN_CNT-1:0]   pinsIn,
  output logic [SRC_CNT-1:0]   status,
  output logic [2*PIN_CNT-1:0] chgReg
);
  localparam int WARM_LEN = SYNC_DEPTH + 1;

  logic [PIN_CNT-1:0] syncPipe [SYNC_DEPTH];
  logic [PIN_CNT-1:0] lvl;
  logic [PIN_CNT-1:0] prevLvl;
  logic [PIN_CNT-1:0] deltaReg;
  logic [PIN_CNT-1:0] changeNow;
  logic [WARM_LEN-1:0] warm;
  logic [EXT_CNT-1:0] evtReg;

  // synchronizer chain, depth chosen by parameter
  for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or posedge rst) begin
        if (rst) syncPipe[s] <= '0;
        else     syncPipe[s] <= pinsIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or posedge rst) begin
        if (rst) syncPipe[s] <= '0;
        else     syncPipe[s] <= syncPipe[s-1];
      end
    end
  end

  assign lvl = syncPipe[SYNC_DEPTH-1];

  // comparison enabled only once both compared samples are real pin data
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      warm    <= '0;
      prevLvl <= '0;
    end else begin
      warm    <= {warm[WARM_LEN-2:0], 1'b1};
      prevLvl <= lvl;
    end
  end

  assign changeNow = warm[WARM_LEN-1] ? (lvl ^ prevLvl) : '0;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      deltaReg <= '0;
      evtReg   <= '0;
    end else begin
      deltaReg <= (deltaReg & ~{PIN_CNT{strb.clrDelta}}) | changeNow;
      evtReg   <= (evtReg & ~strb.clrEvt) | evtSet;
    end
  end

  assign status = {|deltaReg, evtReg};
  assign chgReg = {deltaReg, lvl};
endmodule

// File: rtl/change_irq_unit.sv
module change_irq_unit
  import irq_pkg::*;
#(
  parameter int PIN_CNT    = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [6:0]           evtSet,
  input  logic [1:0]           rxDataRd,
  input  logic [1:0]           txDataWr,
  input  logic [1:0]           breakRstCmd,
  input  logic                 ctrStopCmd,
  input  logic                 chgRd,
  input  logic                 maskWr,
  input  logic [7:0]           maskData,
  input  logic [PIN_CNT-1:0]   pinsIn,
  output logic                 irqN,
  output logic [7:0]           status,
  output logic [2*PIN_CNT-1:0] chgReg
);
  strobe_t strb;

  irq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .rxDataRd(rxDataRd), .txDataWr(txDataWr),
    .breakRstCmd(breakRstCmd), .ctrStopCmd(ctrStopCmd), .chgRd(chgRd),
    .maskWr(maskWr), .maskData(maskData), .status(status),
    .strb(strb), .irqN(irqN)
  );

  irq_datapath #(.PIN_CNT(PIN_CNT), .SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .clk(clk), .rst(rst), .evtSet(evtSet), .strb(strb), .pinsIn(pinsIn),
    .status(status), .chgReg(chgReg)
  );
endmodule

// File: rtl/change_irq_unit_chk.sv
module change_irq_unit_chk #(
  parameter int PIN_CNT = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [6:0]           evtSet,
  input logic [1:0]           rxDataRd,
  input logic                 ctrStopCmd,
  input logic                 chgRd,
  input logic                 maskWr,
  input logic [7:0]           maskData,
  input logic                 irqN,
  input logic [7:0]           status,
  input logic [2*PIN_CNT-1:0] chgReg
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (status == 8'h00 && irqN));

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
    evtSet[3] |=> status[3]);

  assert_zero_mask_releases_R3: assert property (@(posedge clk) disable iff (rst)
    (maskWr && maskData == 8'h00) |=> irqN);

  assert_rx_clear_only_on_read_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(status[1]) |-> $past(rxDataRd[0]));

  assert_ctr_clear_only_on_stop_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(status[3]) |-> $past(ctrStopCmd));

  assert_flags_drop_only_on_read_R9: assert property (@(posedge clk) disable iff (rst)
    (|($past(chgReg[2*PIN_CNT-1:PIN_CNT]) & ~chgReg[2*PIN_CNT-1:PIN_CNT]))
      |-> $past(chgRd));
endmodule

bind change_irq_unit change_irq_unit_chk #(.PIN_CNT(PIN_CNT)) u_chk (
  .clk(clk), .rst(rst), .evtSet(evtSet), .rxDataRd(rxDataRd),
  .ctrStopCmd(ctrStopCmd), .chgRd(chgRd), .maskWr(maskWr),
  .maskData(maskData), .irqN(irqN), .status(status), .chgReg(chgReg)
);

// File: tb/test_change_irq_unit.sv
`timescale 1ns/1ps
module test_change_irq_unit;
  typedef struct {
    logic [7:0] st;
    logic [7:0] chg;
    logic       irq;
    string      tag;
  } exp_t;

  logic       clk = 0;
  logic       rst = 1;
  logic [6:0] evtSet = '0;
  logic [1:0] rxDataRd = '0, txDataWr = '0, breakRstCmd = '0;
  logic       ctrStopCmd = 0, chgRd = 0, maskWr = 0;
  logic [7:0] maskData = '0;
  logic [3:0] pinsIn = 4'b0101;
  logic       irqN;
  logic [7:0] status, chgReg;

  int total = 0, bad = 0;
  bit done = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  change_irq_unit i_change_irq_unit (
    .clk(clk), .rst(rst), .evtSet(evtSet), .rxDataRd(rxDataRd),
    .txDataWr(txDataWr), .breakRstCmd(breakRstCmd), .ctrStopCmd(ctrStopCmd),
    .chgRd(chgRd), .maskWr(maskWr), .maskData(maskData), .pinsIn(pinsIn),
    .irqN(irqN), .status(status), .chgReg(chgReg)
  );

  // driver: inputs set before call apply at next edge; expectation is state after it
  task automatic tick(input logic [7:0] st, input logic [7:0] chg,
                      input logic irq, input string tag);
    exp_t e;
    @(posedge clk);
    e.st = st; e.chg = chg; e.irq = irq; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    evtSet = '0; rxDataRd = '0; txDataWr = '0; breakRstCmd = '0;
    ctrStopCmd = 0; chgRd = 0; maskWr = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (status !== e.st || chgReg !== e.chg || irqN !== e.irq) begin
          bad++;
          $display("FAIL %s: status=%h chg=%h irqN=%b expected status=%h chg=%h irqN=%b",
                   e.tag, status, chgReg, irqN, e.st, e.chg, e.irq);
        end
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (status !== 8'h00 || irqN !== 1'b1 || chgReg[7:4] !== 4'h0) begin
      bad++;
      $display("FAIL R1 in reset: status=%h irqN=%b flags=%h expected 00 1 0",
               status, irqN, chgReg[7:4]);
    end
    rst = 0;
    tick(8'h00, 8'h00, 1, "R1 first cycle");
    tick(8'h00, 8'h05, 1, "R7 levels visible");
    tick(8'h00, 8'h05, 1, "R11 no flag");
    tick(8'h00, 8'h05, 1, "R11 still no flag");
    maskData = 8'hFF; maskWr = 1;
    tick(8'h00, 8'h05, 1, "R3 mask load");
    evtSet[3] = 1;
    tick(8'h08, 8'h05, 0, "R2 counter set");
    tick(8'h08, 8'h05, 0, "R2 holds");
    ctrStopCmd = 1;
    tick(8'h00, 8'h05, 1, "R5 stop counter");
    evtSet[1] = 1;
    tick(8'h02, 8'h05, 0, "R2 rx A set");
    txDataWr[1] = 1;
    tick(8'h02, 8'h05, 0, "R4 other clear no effect");
    rxDataRd[0] = 1;
    tick(8'h00, 8'h05, 1, "R4 rx A read");
    evtSet[0] = 1; txDataWr[0] = 1;
    tick(8'h01, 8'h05, 0, "R6 set wins");
    txDataWr[0] = 1;
    tick(8'h00, 8'h05, 1, "R4 tx A write");
    evtSet[2] = 1; evtSet[6] = 1;
    tick(8'h44, 8'h05, 0, "R2 breaks set");
    breakRstCmd[0] = 1;
    tick(8'h40, 8'h05, 0, "R5 break A reset");
    breakRstCmd[1] = 1;
    tick(8'h00, 8'h05, 1, "R5 break B reset");
    evtSet[5] = 1; evtSet[4] = 1;
    tick(8'h30, 8'h05, 0, "R2 B set");
    txDataWr[1] = 1;
    tick(8'h20, 8'h05, 0, "R4 tx B write");
    maskData = 8'hDF; maskWr = 1;
    tick(8'h20, 8'h05, 1, "R3 masked release");
    maskData = 8'hFF; maskWr = 1;
    tick(8'h20, 8'h05, 0, "R3 unmask");
    rxDataRd[1] = 1;
    tick(8'h00, 8'h05, 1, "R4 rx B read");
    pinsIn = 4'b0111;
    tick(8'h00, 8'h05, 1, "R7 first stage");
    tick(8'h00, 8'h07, 1, "R7 second stage");
    tick(8'h80, 8'h27, 0, "R8 rise flagged");
    tick(8'h80, 8'h27, 0, "R8 sticky");
    chgRd = 1;
    tick(8'h00, 8'h07, 1, "R9 read clears");
    pinsIn = 4'b1111;
    tick(8'h00, 8'h07, 1, "R10 stage1");
    tick(8'h00, 8'h0F, 1, "R10 stage2");
    chgRd = 1;
    tick(8'h80, 8'h8F, 0, "R10 kept across read");
    chgRd = 1;
    tick(8'h00, 8'h0F, 1, "R9 second read");
    pinsIn = 4'b1110;
    tick(8'h00, 8'h0F, 1, "R8 fall stage1");
    tick(8'h00, 8'h0E, 1, "R8 fall stage2");
    tick(8'h80, 8'h1E, 0, "R8 fall flagged");
    maskData = 8'h7F; maskWr = 1;
    tick(8'h80, 8'h1E, 1, "R3 change masked");
    chgRd = 1;
    tick(8'h00, 8'h0E, 1, "R9 final read");
    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule